// File: doc/BRIEF.md
# Wiper Position Counter with One-Hot Tap Decode

This block keeps the 8-bit position of a digitally controlled resistor-ladder wiper. It also turns that position into a 256-bit tap-enable vector with exactly one bit set. Bit 0 of the vector is the switch at the low end of the ladder, and bit 255 is the switch at the high end.

The position can change in four ways:
- A host byte write sets it to a new value.
- A parallel copy takes the value of one of four data-register slots on the `bank_regs` bus.
- A single step moves it up or down by one, with the direction taken from a level input.
- A synchronous reset reloads it from slot 0.

When several sources strike in the same cycle, reset wins, then the write, then the copy, then the step. The tap vector is registered, so it follows the position one cycle later.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, `pos` loads slot 0 (`bank_regs[7:0]`) and `taps` is set to 1 (tap 0). In the first cycle after reset ends, `taps` has only the bit indexed by the recalled value set.
- R2: `wr_en` high at an edge loads `wr_data` into `pos` at that edge.
- R3: `xfr_en` high at an edge loads slot `xfr_sel` into `pos`. Slot k sits at `bank_regs[8k+7:8k]`.
- R4: `step_en` high at an edge with `step_up`=1 adds one to `pos`; with `step_up`=0 it subtracts one.
- R5: Stepping saturates. An up-step at 0xFF leaves 0xFF, and a down-step at 0x00 leaves 0x00.
- R6: When strobes arrive together, the write wins over the copy, and the copy wins over the step.
- R7: With no strobe and no reset, `pos` holds its value whatever `wr_data`, `xfr_sel`, `step_up` and `bank_regs` do.
- R8: `taps` always has exactly one bit set.
- R9: Outside reset, `taps` has bit `p` set, where `p` is the value `pos` held one cycle earlier. Position 0x00 maps to bit 0 (low end) and 0xFF maps to bit 255 (high end).
- R10: Reset takes priority over any write, copy or step strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; recalls slot 0 into the position |
| wr_en | input | 1 | Direct byte write strobe |
| wr_data | input | 8 | Byte for a direct write |
| xfr_en | input | 1 | Parallel copy strobe |
| xfr_sel | input | 2 | Slot index for a parallel copy |
| bank_regs | input | 32 | Four 8-bit data-register slots; slot 0 is the recall value |
| step_en | input | 1 | Single-step strobe |
| step_up | input | 1 | Step direction: 1 toward the high end, 0 toward the low end |
| pos | output | 8 | Current wiper position |
| taps | output | 256 | Registered one-hot tap enables |

## Verification
A table of vectors exercises each load source on its own:
- writes to both end values;
- copies from every slot;
- steps in both directions, including steps into each rail.

The table also drives combined strobes in the same cycle, which separates the write-over-copy order from the copy-over-step order. Reset is asserted together with active strobes to show that recall wins. Idle cycles with busy data inputs show that nothing leaks into the held position. Every cycle checks the tap vector against the position of the cycle before, so a missing or extra pipeline stage is exposed.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    localparam int POS_W    = 8;
    localparam int NUM_TAPS = 1 << POS_W;
    localparam int NUM_DR   = 4;
    localparam int SEL_W    = $clog2(NUM_DR);
    localparam int BANK_W   = NUM_DR * POS_W;

    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_WRITE = 2'd1,
        SRC_XFER  = 2'd2,
        SRC_STEP  = 2'd3
    } src_e;

    typedef struct packed {
        logic load;
        src_e src;
        pos_t value;
    } upd_t;

    // Saturating single step toward either rail.
    function automatic pos_t step_sat(input pos_t cur, input logic up);
        pos_t res;
        if (up) begin
            res = (cur == {POS_W{1'b1}}) ? cur : cur + pos_t'(1);
        end else begin
            res = (cur == '0) ? cur : cur - pos_t'(1);
        end
        return res;
    endfunction

endpackage

// File: rtl/wiper_load_arb.sv
module wiper_load_arb
    import wiper_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  pos_t                wr_data,
    input  logic                xfr_en,
    input  logic [SEL_W-1:0]    xfr_sel,
    input  logic [BANK_W-1:0]   bank_regs,
    input  logic                step_en,
    input  logic                step_up,
    input  pos_t                cur,
    output upd_t                upd
);

    pos_t slots [NUM_DR];

    genvar g;
    generate
        for (g = 0; g < NUM_DR; g++) begin : g_slot
            assign slots[g] = bank_regs[g*POS_W +: POS_W];
        end
    endgenerate

    always_comb begin
        upd = '{load: 1'b0, src: SRC_NONE, value: cur};
        if (wr_en) begin
            upd = '{load: 1'b1, src: SRC_WRITE, value: wr_data};
        end else if (xfr_en) begin
            upd = '{load: 1'b1, src: SRC_XFER, value: slots[xfr_sel]};
        end else if (step_en) begin
            upd = '{load: 1'b1, src: SRC_STEP, value: step_sat(cur, step_up)};
        end
    end

    AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
        (step_en && step_up && !wr_en && !xfr_en && cur == {POS_W{1'b1}})
            |-> (upd.value == cur)); // R5
    AST_SAT_BOT: assert property (@(posedge clk) disable iff (rst)
        (step_en && !step_up && !wr_en && !xfr_en && cur == '0)
            |-> (upd.value == '0)); // R5
    AST_WR_FIRST: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (upd.src == SRC_WRITE && upd.value == wr_data)); // R6
    AST_XFR_OVER_STEP: assert property (@(posedge clk) disable iff (rst)
        (xfr_en && step_en && !wr_en) |-> (upd.src == SRC_XFER)); // R6

endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
    import wiper_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pos_t recall,
    input  upd_t upd,
    output pos_t pos
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= recall;
        end else if (upd.load) begin
            pos <= upd.value;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !upd.load |=> $stable(pos)); // R7

endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode
    import wiper_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  pos_t                pos,
    output logic [NUM_TAPS-1:0] taps
);

    logic [NUM_TAPS-1:0] hit;

    genvar i;
    generate
        for (i = 0; i < NUM_TAPS; i++) begin : g_tap
            assign hit[i] = (pos == pos_t'(i));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= NUM_TAPS'(1);
        end else begin
            taps <= hit;
        end
    end

    AST_TAPS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(taps) == 1); // R8
    AST_TAP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> taps[$past(pos)]); // R9

endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl
    import wiper_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [POS_W-1:0]    wr_data,
    input  logic                xfr_en,
    input  logic [SEL_W-1:0]    xfr_sel,
    input  logic [BANK_W-1:0]   bank_regs,
    input  logic                step_en,
    input  logic                step_up,
    output logic [POS_W-1:0]    pos,
    output logic [NUM_TAPS-1:0] taps
);

    upd_t upd;
    pos_t pos_q;

    wiper_load_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .xfr_en    (xfr_en),
        .xfr_sel   (xfr_sel),
        .bank_regs (bank_regs),
        .step_en   (step_en),
        .step_up   (step_up),
        .cur       (pos_q),
        .upd       (upd)
    );

    wiper_pos_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .recall (bank_regs[POS_W-1:0]),
        .upd    (upd),
        .pos    (pos_q)
    );

    wiper_tap_decode u_dec (
        .clk  (clk),
        .rst  (rst),
        .pos  (pos_q),
        .taps (taps)
    );

    assign pos = pos_q;

    AST_RECALL_WINS: assert property (@(posedge clk)
        rst |=> (pos == $past(bank_regs[POS_W-1:0]))); // R10
    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (pos == $past(wr_data))); // R2

endmodule

// File: tb/sim_wiper_pos_ctrl.sv
module sim_wiper_pos_ctrl;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_data = '0;
    logic         xfr_en = 1'b0;
    logic [1:0]   xfr_sel = '0;
    logic [31:0]  bank_regs = 32'h80FE_015A; // slot3=80 slot2=FE slot1=01 slot0=5A
    logic         step_en = 1'b0;
    logic         step_up = 1'b0;
    logic [7:0]   pos;
    logic [255:0] taps;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wiper_pos_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .xfr_en(xfr_en), .xfr_sel(xfr_sel), .bank_regs(bank_regs),
        .step_en(step_en), .step_up(step_up), .pos(pos), .taps(taps)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] d;
        logic       xf;
        logic [1:0] sel;
        logic       st;
        logic       up;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h10, 1'b0, 2'd0, 1'b0, 1'b0, 8'h10}, // R2 write
        '{1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 8'h10}, // R7 idle
        '{1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b1, 8'h11}, // R4 up
        '{1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 8'h10}, // R4 down
        '{1'b0, 8'h00, 1'b1, 2'd1, 1'b0, 1'b0, 8'h01}, // R3 slot1
        '{1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 8'h00}, // R4 down to rail
        '{1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 8'h00}, // R5 low saturate
        '{1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 8'hFE}, // R3 slot2
        '{1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b1, 8'hFF}, // R4 up to rail
        '{1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b1, 8'hFF}, // R5 high saturate
        '{1'b1, 8'h33, 1'b1, 2'd3, 1'b1, 1'b1, 8'h33}, // R6 write wins
        '{1'b0, 8'h00, 1'b1, 2'd3, 1'b1, 1'b0, 8'h80}, // R6 copy beats step
        '{1'b0, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0, 8'h5A}, // R3 slot0
        '{1'b1, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 8'h00}, // R2 low end
        '{1'b1, 8'hFF, 1'b0, 2'd0, 1'b0, 1'b0, 8'hFF}  // R2 high end
    };

    task automatic check_pos(input string tag, input logic [7:0] exp);
        checks++;
        if (pos !== exp) begin
            errors++;
            $display("FAIL %s pos actual=%02h expected=%02h", tag, pos, exp);
        end
    endtask

    task automatic check_tap(input string tag, input logic [7:0] idx);
        checks++;
        if ($countones(taps) != 1 || taps[idx] !== 1'b1) begin
            errors++;
            $display("FAIL %s taps actual: %0d bits set, bit[%0d]=%b expected: single bit %0d",
                     tag, $countones(taps), idx, taps[idx], idx);
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] prev;
        repeat (2) @(negedge clk);
        check_pos("R1 recall during reset", 8'h5A);
        checks++;
        if (taps !== 256'd1) begin
            errors++;
            $display("FAIL R1 reset taps actual ones=%0d bit0=%b expected only bit 0",
                     $countones(taps), taps[0]);
        end
        rst = 1'b0;
        @(negedge clk);
        check_pos("R1 recall held", 8'h5A);
        check_tap("R1 R9 first tap after reset", 8'h5A);
        prev = 8'h5A;

        for (int i = 0; i < NV; i++) begin
            wr_en   = VECS[i].wr;
            wr_data = VECS[i].d;
            xfr_en  = VECS[i].xf;
            xfr_sel = VECS[i].sel;
            step_en = VECS[i].st;
            step_up = VECS[i].up;
            @(negedge clk);
            check_pos($sformatf("R2/R3/R4/R5/R6 table row %0d", i), VECS[i].exp);
            check_tap($sformatf("R8 R9 table row %0d", i), prev);
            prev = VECS[i].exp;
        end
        wr_en = 1'b0; xfr_en = 1'b0; step_en = 1'b0;
        @(negedge clk);
        check_tap("R9 high end tap 255", 8'hFF);

        // Reset together with every strobe: recall must win.
        rst = 1'b1; wr_en = 1'b1; wr_data = 8'h77; xfr_en = 1'b1; xfr_sel = 2'd2;
        step_en = 1'b1; step_up = 1'b0;
        @(negedge clk);
        check_pos("R10 reset beats strobes", 8'h5A);
        rst = 1'b0; wr_en = 1'b0; xfr_en = 1'b0; step_en = 1'b0;

        // Idle with busy data inputs: position must hold.
        for (int k = 0; k < 3; k++) begin
            wr_data   = 8'hA0 + 8'(k);
            xfr_sel   = 2'(k + 1);
            step_up   = k[0];
            bank_regs = 32'h1122_3344 + 32'(k);
            @(negedge clk);
            check_pos("R7 hold with no strobe", 8'h5A);
            check_tap("R9 R8 tap while holding", 8'h5A);
        end

        // Step down from 1 to 0 and check the low-end tap.
        wr_en = 1'b1; wr_data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0; step_en = 1'b1; step_up = 1'b0;
        @(negedge clk);
        step_en = 1'b0;
        check_pos("R4 down to zero", 8'h00);
        @(negedge clk);
        check_tap("R9 low end tap 0", 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule